// File: doc/BRIEF.md
# Configurable Pixel Stream Transform

This stage sits between a pixel producer and a panel driver and rewrites a stream of 24-bit RGB pixels. Each pixel holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Five configuration bits choose the transforms:

- bit 0 inverts every colour component.
- bit 1 shifts the low six bits of each component up by two places.
- bit 2 exchanges red and blue.
- bit 3 emits each line in reverse order.
- bit 4 makes the idle colour white; when it is clear the idle colour is black.

Both sides use valid/ready handshakes and mark the first and last pixel of each line. The component steps run in a fixed order: the shift first, then the inversion, then the red/blue exchange. The configuration is sampled only when the first pixel of a line is accepted, so the whole line uses one setting.

A small state machine controls the stage. It has four states:

- **IDLE**: between lines. The stage emits the idle colour as filler, with valid high.
- **PASS**: a line in progress in forward mode. Pixels go straight through with no added latency.
- **FILL**: in reverse mode, a line is being captured into a one-line buffer.
- **DRAIN**: the captured line is emitted from its last pixel back to its first.

The transitions are:

- **start-pass**: IDLE to PASS, when a forward line starts.
- **start-fill**: IDLE to FILL, when a reverse line starts.
- **start-single**: IDLE to DRAIN, when a reverse line is one pixel long.
- **line-done**: PASS to IDLE, on the accepted last pixel.
- **capture-done**: FILL to DRAIN, on the last pixel or when the buffer is full.
- **drain-done**: DRAIN to IDLE, when the drained line's last pixel is accepted.

Top module: `pix_xform`

## Requirements
- R1: After reset the stage is in IDLE with the stored configuration cleared. out_valid is 1, out_data is 0x000000 (black), out_sol and out_eol are 0, and in_ready is 1.
- R2: With all transforms off, a forward line passes through in the same cycle. Data is unchanged, out_sol is set on the first pixel, out_eol copies in_eol, and in_ready equals out_ready.
- R3: With bit 0 set, each 8-bit component D is output as 255 − D.
- R4: With bit 1 set, component bits 5:0 appear at bits 7:2 and bits 1:0 are zero.
- R5: With several bits set, the shift is applied first, then the inversion, then the red/blue exchange. With bits 0 and 1 set, every component's low two bits are therefore 1.
- R6: With bit 2 set, output bits 23:16 carry input blue and output bits 7:0 carry input red. Green is unchanged.
- R7: With bit 3 set, the stage works as follows.
  - While a line is captured, out_valid is 0 and in_ready is 1.
  - After the last input pixel, the line is emitted in reverse order with out_sol on the first emitted pixel and out_eol on the last.
  - While the line is emitted, in_ready is 0.
- R8: In reverse mode, a line longer than LINE_MAX ends its capture at LINE_MAX pixels and drains those pixels. The remaining input pixels arrive without a start mark and are discarded.
- R9: The configuration is taken from cfg_i only when a start-of-line pixel is accepted. Changes to cfg_i during a line do not affect that line.
- R10: In IDLE, with no start-of-line pixel offered, out_valid is 1 with out_sol and out_eol low. out_data is 0xFFFFFF if bit 4 of the last sampled configuration is set, otherwise 0x000000. in_ready is 1, and pixels without a start mark are consumed and dropped.
- R11: When out_ready is low, a drained pixel stays on the output and a forward line stalls its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_i | input | 5 | Transform select bits, sampled at line start |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage accepts the input pixel |
| in_data | input | 24 | Input pixel {R,G,B} |
| in_sol | input | 1 | First pixel of a line |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | 24 | Output pixel {R,G,B} |
| out_sol | output | 1 | First pixel of an output line |
| out_eol | output | 1 | Last pixel of an output line |

## Verification
The bench targets several corner cases, each with a visible failure mode:

- **Transform order.** A design that inverted before shifting would leave zeros, not ones, in the low bits when both bits are set.
- **One-pixel reverse line.** A design that mishandled it would hang in FILL or emit the pixel without its line marks.
- **Lines longer than the buffer.** Without the cut at LINE_MAX, the pointer would wrap over earlier pixels or the overflow pixels would be emitted.
- **Mid-line configuration changes and back-pressure.** These expose a stage that samples cfg_i every cycle, or one that advances its read pointer while out_ready is low.

// File: rtl/pxf_pkg.sv
package pxf_pkg;

    localparam int CFG_W = 5;

    // Configuration word, most significant field first.
    typedef struct packed {
        logic blank_white;  // bit 4
        logic hflip;        // bit 3
        logic swap_rb;      // bit 2
        logic remap;        // bit 1
        logic invert;       // bit 0
    } pxf_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_FILL  = 2'd2,
        ST_DRAIN = 2'd3
    } pxf_state_t;

    typedef enum logic [1:0] {
        SRC_BLANK = 2'd0,
        SRC_PASS  = 2'd1,
        SRC_BUF   = 2'd2
    } pxf_src_t;

endpackage

// File: rtl/pxf_color.sv
module pxf_color #(
    parameter int PIX_W = 8
) (
    input  logic               invert,
    input  logic               remap,
    input  logic               swap_rb,
    input  logic [3*PIX_W-1:0] pix_i,
    output logic [3*PIX_W-1:0] pix_o
);
    localparam int SHIFT = 2;
    localparam int NCH   = 3;

    logic [PIX_W-1:0] stage [NCH];

    // Per-channel: shift first, then invert.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [PIX_W-1:0] raw;
        logic [PIX_W-1:0] mapped;
        assign raw         = pix_i[ch*PIX_W +: PIX_W];
        assign mapped      = remap ? (raw << SHIFT) : raw;
        assign stage[ch]   = invert ? ~mapped : mapped;
    end

    // Channel exchange is the final step; index 2 is red, 0 is blue.
    always_comb begin
        if (swap_rb) begin
            pix_o = {stage[0], stage[1], stage[2]};
        end else begin
            pix_o = {stage[2], stage[1], stage[0]};
        end
    end

endmodule

// File: rtl/pxf_linebuf.sv
module pxf_linebuf #(
    parameter int DW    = 24,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pxf_ctrl.sv
module pxf_ctrl import pxf_pkg::*; #(
    parameter int LINE_MAX = 64,
    localparam int AW      = $clog2(LINE_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sol,
    input  logic          in_eol,
    input  logic          out_ready,
    input  logic          flip,
    output logic          at_start,
    output logic          in_ready,
    output logic          out_valid,
    output logic          out_sol,
    output logic          out_eol,
    output pxf_src_t      src,
    output logic          cfg_load,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr
);
    localparam logic [AW-1:0] LAST = AW'(LINE_MAX - 1);

    pxf_state_t    state_q, state_d;
    logic [AW-1:0] wr_ptr_q, wr_ptr_d;
    logic [AW-1:0] rd_ptr_q, rd_ptr_d;
    logic [AW-1:0] top_q, top_d;

    assign at_start = (state_q == ST_IDLE) && in_valid && in_sol;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            top_q    <= '0;
        end else begin
            state_q  <= state_d;
            wr_ptr_q <= wr_ptr_d;
            rd_ptr_q <= rd_ptr_d;
            top_q    <= top_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        wr_ptr_d = wr_ptr_q;
        rd_ptr_d = rd_ptr_q;
        top_d    = top_q;
        unique case (state_q)
            ST_IDLE: begin
                if (at_start && flip) begin
                    if (in_eol) begin          // start-single
                        state_d  = ST_DRAIN;
                        rd_ptr_d = '0;
                        top_d    = '0;
                    end else begin             // start-fill
                        state_d  = ST_FILL;
                        wr_ptr_d = AW'(1);
                    end
                end else if (at_start && out_ready && !in_eol) begin
                    state_d = ST_PASS;         // start-pass
                end
            end
            ST_PASS: begin
                if (in_valid && out_ready && in_eol) begin
                    state_d = ST_IDLE;         // line-done
                end
            end
            ST_FILL: begin
                if (in_valid) begin
                    if (in_eol || (wr_ptr_q == LAST)) begin
                        state_d  = ST_DRAIN;   // capture-done
                        rd_ptr_d = wr_ptr_q;
                        top_d    = wr_ptr_q;
                    end else begin
                        wr_ptr_d = wr_ptr_q + AW'(1);
                    end
                end
            end
            ST_DRAIN: begin
                if (out_ready) begin
                    if (rd_ptr_q == '0) begin
                        state_d = ST_IDLE;     // drain-done
                    end else begin
                        rd_ptr_d = rd_ptr_q - AW'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_sol   = 1'b0;
        out_eol   = 1'b0;
        src       = SRC_BLANK;
        cfg_load  = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = wr_ptr_q;
        rd_addr   = rd_ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (at_start && flip) begin
                    in_ready = 1'b1;
                    cfg_load = 1'b1;
                    wr_en    = 1'b1;
                    wr_addr  = '0;
                end else if (at_start) begin
                    out_valid = 1'b1;
                    src       = SRC_PASS;
                    in_ready  = out_ready;
                    out_sol   = 1'b1;
                    out_eol   = in_eol;
                    cfg_load  = out_ready;
                end else begin
                    in_ready  = 1'b1;
                    out_valid = 1'b1;
                end
            end
            ST_PASS: begin
                out_valid = in_valid;
                src       = SRC_PASS;
                in_ready  = out_ready;
                out_eol   = in_eol;
            end
            ST_FILL: begin
                in_ready = 1'b1;
                wr_en    = in_valid;
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                src       = SRC_BUF;
                out_sol   = (rd_ptr_q == top_q);
                out_eol   = (rd_ptr_q == '0);
            end
            default: ;
        endcase
    end

    // R7: no input accepted while a captured line is emitted
    p_drain_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> !in_ready);

    // R7: nothing emitted while a line is captured
    p_fill_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> (!out_valid && in_ready));

    // R8: a full buffer ends the capture
    p_cap_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && in_valid && wr_ptr_q == LAST) |=> (state_q == ST_DRAIN));

    // R10: filler between lines
    p_filler_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !in_valid) |-> (out_valid && !out_sol && !out_eol && in_ready));

    // R11: a stalled drain holds its position
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !out_ready) |=> (state_q == ST_DRAIN && $stable(rd_ptr_q)));

endmodule

// File: rtl/pix_xform.sv
module pix_xform import pxf_pkg::*; #(
    parameter int PIX_W    = 8,
    parameter int LINE_MAX = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CFG_W-1:0]   cfg_i,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [3*PIX_W-1:0] in_data,
    input  logic               in_sol,
    input  logic               in_eol,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [3*PIX_W-1:0] out_data,
    output logic               out_sol,
    output logic               out_eol
);
    localparam int DW = 3 * PIX_W;
    localparam int AW = $clog2(LINE_MAX);

    function automatic logic [DW-1:0] low_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int c = 0; c < 3; c++) begin
            m[c*PIX_W]     = 1'b1;
            m[c*PIX_W + 1] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DW-1:0] LOW2 = low_mask();

    pxf_cfg_t      cfg_q, cfg_eff;
    logic          at_start, cfg_load, wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] xf_data, buf_data;
    pxf_src_t      src;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_load) begin
            cfg_q <= pxf_cfg_t'(cfg_i);
        end
    end

    assign cfg_eff = at_start ? pxf_cfg_t'(cfg_i) : cfg_q;

    pxf_color #(.PIX_W(PIX_W)) u_color (
        .invert  (cfg_eff.invert),
        .remap   (cfg_eff.remap),
        .swap_rb (cfg_eff.swap_rb),
        .pix_i   (in_data),
        .pix_o   (xf_data)
    );

    pxf_linebuf #(.DW(DW), .DEPTH(LINE_MAX)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (xf_data),
        .rd_addr (rd_addr),
        .rd_data (buf_data)
    );

    pxf_ctrl #(.LINE_MAX(LINE_MAX)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sol    (in_sol),
        .in_eol    (in_eol),
        .out_ready (out_ready),
        .flip      (cfg_eff.hflip),
        .at_start  (at_start),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_sol   (out_sol),
        .out_eol   (out_eol),
        .src       (src),
        .cfg_load  (cfg_load),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr)
    );

    always_comb begin
        unique case (src)
            SRC_PASS: out_data = xf_data;
            SRC_BUF:  out_data = buf_data;
            default:  out_data = {DW{cfg_q.blank_white}};
        endcase
    end

    // R4: a shifted, non-inverted pixel has zero low bits in every channel
    p_remap_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && src == SRC_PASS && cfg_eff.remap && !cfg_eff.invert)
        |-> ((out_data & LOW2) == '0));

    // R9: the stored configuration moves only on an accepted line start
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_sol && in_ready) |=> $stable(cfg_q));

endmodule

// File: tb/pix_xform_bench.sv
`timescale 1ns/1ps
module pix_xform_bench;
    localparam int LM = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  cfg_i = '0;
    logic        in_valid = 0, in_sol = 0, in_eol = 0, out_ready = 1;
    logic [23:0] in_data = '0;
    logic        in_ready, out_valid, out_sol, out_eol;
    logic [23:0] out_data;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    mon_on = 0, rnd_ready = 0;

    always #5 clk = ~clk;

    pix_xform #(.PIX_W(8), .LINE_MAX(LM)) u_pix_xform (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sol(in_sol), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sol(out_sol), .out_eol(out_eol)
    );

    task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // Reference transform from R3..R6: shift, then 255-v, then swap.
    function automatic logic [23:0] ref_xf(logic [23:0] d, logic [4:0] c);
        int v [3];
        int t;
        for (int i = 0; i < 3; i++) begin
            v[i] = int'(d[i*8 +: 8]);
            if (c[1]) v[i] = (v[i] * 4) % 256;
            if (c[0]) v[i] = 255 - v[i];
        end
        if (c[2]) begin t = v[0]; v[0] = v[2]; v[2] = t; end
        return {v[2][7:0], v[1][7:0], v[0][7:0]};
    endfunction

    // Behavioural model, compared every cycle
    int          m_state = 0;  // 0 idle, 1 forward, 2 capture, 3 emit
    logic [4:0]  m_cfg = '0;
    logic [23:0] m_q [$];
    int          m_len = 0;

    always @(negedge clk) begin
        logic ev, es, ee, er, start;
        logic [23:0] ed;
        logic [4:0]  c;
        if (mon_on) begin
            ev = 0; es = 0; ee = 0; er = 0; ed = '0;
            start = in_valid && in_sol;
            c = (m_state == 0 && start) ? cfg_i : m_cfg;
            case (m_state)
                0: if (start && c[3]) er = 1;
                   else if (start) begin ev = 1; ed = ref_xf(in_data, c); es = 1; ee = in_eol; er = out_ready; end
                   else begin ev = 1; ed = {24{m_cfg[4]}}; er = 1; end
                1: begin ev = in_valid; ed = ref_xf(in_data, m_cfg); ee = in_eol; er = out_ready; end
                2: er = 1;
                default: begin ev = 1; ed = m_q[$]; es = (m_q.size() == m_len); ee = (m_q.size() == 1); end
            endcase
            chk(in_ready == er, "in_ready", 32'(in_ready), 32'(er));
            chk(out_valid == ev, "out_valid", 32'(out_valid), 32'(ev));
            if (ev) begin
                chk(out_data == ed, "out_data", 32'(out_data), 32'(ed));
                chk(out_sol == es, "out_sol", 32'(out_sol), 32'(es));
                chk(out_eol == ee, "out_eol", 32'(out_eol), 32'(ee));
            end
            case (m_state)
                0: if (start && c[3]) begin
                       m_cfg = c; m_q = {}; m_q.push_back(ref_xf(in_data, c));
                       if (in_eol) begin m_len = 1; m_state = 3; end else m_state = 2;
                   end else if (start && out_ready) begin
                       m_cfg = c; if (!in_eol) m_state = 1;
                   end
                1: if (in_valid && out_ready && in_eol) m_state = 0;
                2: if (in_valid) begin
                       m_q.push_back(ref_xf(in_data, m_cfg));
                       if (in_eol || m_q.size() == LM) begin m_len = m_q.size(); m_state = 3; end
                   end
                default: if (out_ready) begin
                       void'(m_q.pop_back());
                       if (m_q.size() == 0) m_state = 0;
                   end
            endcase
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
        end
    end

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic send_pix(logic [23:0] d, logic s, logic e);
        bit acc;
        in_data = d; in_sol = s; in_eol = e; in_valid = 1;
        acc = 0;
        while (!acc) begin
            @(negedge clk); acc = in_ready;
            @(posedge clk); #1;
        end
        in_valid = 0; in_sol = 0; in_eol = 0;
    endtask

    task automatic send_line(int n, logic [4:0] c, logic [4:0] mid_c, bit gaps);
        cfg_i = c;
        for (int k = 0; k < n; k++) begin
            if (k == 1) cfg_i = mid_c;
            send_pix(24'($urandom), k == 0, k == n - 1);
            if (gaps && ($urandom % 3) == 0) idle(1);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL all watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(7));
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(out_valid && out_data == 24'h0 && !out_sol && !out_eol && in_ready,
            "reset state", {out_valid, in_ready, out_sol, out_eol, 4'h0, out_data}, 32'hC0000000);
        mon_on = 1;
        @(posedge clk); #1;

        cur_req = "R2";  // plain forward lines
        send_line(4, 5'b00000, 5'b00000, 0);
        send_line(1, 5'b00000, 5'b00000, 0);
        cur_req = "R11"; rnd_ready = 1;  // back-pressure on forward path
        send_line(6, 5'b00000, 5'b00000, 1);
        rnd_ready = 0;
        cur_req = "R3";  send_line(5, 5'b00001, 5'b00001, 1);
        cur_req = "R4";  send_line(5, 5'b00010, 5'b00010, 0);
        cur_req = "R6";  send_line(5, 5'b00100, 5'b00100, 0);
        cur_req = "R5";  send_line(5, 5'b00111, 5'b00111, 1);
        send_line(3, 5'b00011, 5'b00011, 0);
        cur_req = "R7";  // reverse lines: normal, single, exactly full
        send_line(5, 5'b01000, 5'b01000, 1);
        send_line(1, 5'b01000, 5'b01000, 0);
        send_line(LM, 5'b01101, 5'b01101, 0);
        cur_req = "R11"; rnd_ready = 1;  // stalled drain
        send_line(6, 5'b01000, 5'b01000, 1);
        send_line(4, 5'b00001, 5'b00001, 1);
        idle(10);
        rnd_ready = 0;
        cur_req = "R8";  // overlong reverse line
        send_line(LM + 3, 5'b01000, 5'b01000, 0);
        idle(4);
        send_line(3, 5'b01100, 5'b01100, 0);
        idle(6);
        cur_req = "R9";  // mid-line changes ignored
        send_line(5, 5'b00000, 5'b00111, 0);
        send_line(5, 5'b01001, 5'b00000, 0);
        idle(8);
        send_line(3, 5'b00000, 5'b01000, 0);
        cur_req = "R10"; // filler colour and stray pixels
        send_line(2, 5'b10000, 5'b10000, 0);
        idle(4);
        send_pix(24'h123456, 0, 0);
        send_pix(24'h654321, 0, 1);
        idle(3);
        send_line(2, 5'b11000, 5'b11000, 0);
        idle(6);
        send_line(2, 5'b00000, 5'b00000, 0);
        idle(4);
        mon_on = 0;
        summary();
        $finish;
    end
endmodule